// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block runs the command side of one shortened SDRAM read. A request gives a bank, a start column, the number of words wanted and an auto-precharge flag. The block checks the request against the configured burst mode and CAS latency. It then puts a READ on the command and address pins and fills the other command slots with NOP. When fewer words are wanted than the burst would deliver, it stops the burst with either a BURST TERMINATE or a PRECHARGE of the same bank. It captures the returning 32-bit words and hands them out with a valid strobe.

Placement of the stop command follows from the device rule. The stop must land (CAS latency - 1) cycles before the edge at which the last wanted word is valid. Data word i is sampled CL + i edges after the READ is sampled. The stop command therefore always sits exactly `len` cycles after the READ cycle, whatever the latency.

The controller is a state machine with these states:

| State | Meaning |
|-------|---------|
| ST_IDLE | Waiting for a request. |
| ST_REJECT | A request was refused; the error is shown for one cycle. |
| ST_ISSUE | READ is on the bus. |
| ST_GAP | NOP slots before the stop slot. |
| ST_STOP | The stop slot. |
| ST_DRAIN | NOP slots until the last wanted word is captured. |

The transitions are:

- **accept**: IDLE or REJECT to ISSUE, on a valid request.
- **refuse**: IDLE or REJECT to REJECT, on an invalid request.
- **to_gap**: ISSUE or GAP to GAP, while a stop is pending and the stop slot has not come.
- **to_stop**: ISSUE or GAP to STOP, in the stop slot.
- **no_cut**: ISSUE to DRAIN, when no stop is needed.
- **settle**: STOP to DRAIN.
- **finish**: STOP or DRAIN to IDLE, after the last capture.
- **rest**: IDLE or REJECT to IDLE, when no request arrives.

Top module: `rd_trunc_seq`

## Requirements
- R1: While reset is held and in the first cycle after it: busy, rd_valid and req_err are 0, the bus carries NOP, and sd_dqm is all ones.
- R2: The command pins {cs_n,ras_n,cas_n,we_n} use these patterns: READ 0101, BURST TERMINATE 0110, PRECHARGE 0010 and NOP 0111. Every cycle that carries none of the first three carries NOP.
- R3: A valid request sampled while busy is low puts READ on the bus in the next cycle. In that cycle sd_ba is the bank, sd_addr[7:0] is the column, sd_addr[10] is the auto-precharge flag and the other address bits are 0. busy rises in that same cycle.
- R4: Counting the READ cycle as cycle 0, rd_valid is high in cycles CL+1 to CL+len and nowhere else. In cycle k of that window, rd_data equals the sd_dq_in value present during cycle k-1.
- R5: When len is below the burst length and req_close is 0, exactly one BURST TERMINATE is issued, in cycle len. That slot is CL-1 cycles before the edge carrying the last wanted word. Address and bank are 0 in that slot.
- R6: When len is below the burst length and req_close is 1, the stop slot carries PRECHARGE instead. In that slot sd_ba is the bank and sd_addr is 0, so sd_addr[10] is 0 and only that bank closes.
- R7: When len equals the burst length, only NOP follows the READ.
- R8: A request is refused in any of these cases: len is 0; len exceeds the burst length; the CAS latency is not 1, 2 or 3; auto precharge is set with a full-page burst; auto precharge is set with len below a fixed burst. A refused request raises req_err for exactly the next cycle, issues no READ, and leaves busy low.
- R9: busy stays high from the READ cycle through cycle CL+len-1 and is low in the cycle that shows the last word. Requests arriving while busy is high raise no error and change no command.
- R10: Burst length is 1, 2, 4 or 8 for cfg_bl_code 0, 1, 2 or 3. When cfg_full_page is 1 it is 256 words. Configuration is sampled at the accept edge.
- R11: sd_dqm is all zeros while busy is high and all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_bl_code | input | 2 | Fixed burst length code |
| cfg_full_page | input | 1 | Full-page burst mode |
| req_valid | input | 1 | Request strobe |
| req_bank | input | 2 | Bank to read |
| req_col | input | 8 | Starting column |
| req_len | input | 9 | Number of words wanted |
| req_ap | input | 1 | Auto precharge for the READ |
| req_close | input | 1 | Stop with PRECHARGE instead of terminate |
| req_err | output | 1 | Request refused (one cycle) |
| busy | output | 1 | Read in progress |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_in | input | 32 | Read data from the device |
| rd_data | output | 32 | Captured word |
| rd_valid | output | 1 | rd_data holds a wanted word |

## Verification
Directed reads cover each CAS latency with the same shortened length. This shows that the stop slot stays fixed relative to the READ while the data window moves. Close and no-close pairs separate the terminate path from the precharge path. Full-length reads, single-word reads, full-page reads and auto-precharge reads show that no stop is issued when none is due. Invalid combinations are sent to the refusal path. Seeded random reads then mix burst codes, latencies and lengths, and stray requests are sent while busy is high.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_ISSUE,
        ST_GAP,
        ST_STOP,
        ST_DRAIN
    } rts_state_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_READ,
        OP_TERM,
        OP_PRE
    } rts_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } rts_pins_t;

    function automatic rts_pins_t op_pins(rts_op_e op);
        rts_pins_t p;
        unique case (op)
            OP_READ: p = 4'b0101;
            OP_TERM: p = 4'b0110;
            OP_PRE:  p = 4'b0010;
            default: p = 4'b0111;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rts_req_check.sv
module rts_req_check #(
    parameter int COL_W = 8
) (
    input  logic [1:0]       cas_lat,
    input  logic [1:0]       bl_code,
    input  logic             full_page,
    input  logic [COL_W:0]   len,
    input  logic             ap,
    input  logic             close_row,
    output logic             ok,
    output logic             trunc,
    output logic             use_pre
);
    localparam int LEN_W = COL_W + 1;
    localparam int unsigned FULL = 1 << COL_W;

    logic [LEN_W-1:0] burst;

    always_comb begin
        burst   = full_page ? LEN_W'(FULL) : (LEN_W'(1) << bl_code);
        trunc   = len < burst;
        use_pre = trunc && close_row;
        ok      = (len != '0) && (len <= burst) && (cas_lat != 2'd0)
                  && !(ap && (full_page || trunc));
    end

endmodule

// File: rtl/rts_cmd_enc.sv
module rts_cmd_enc
    import rts_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  rts_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              ap,
    output rts_pins_t         pins,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        pins = op_pins(op);
        ba   = '0;
        addr = '0;
        unique case (op)
            OP_READ: begin
                ba                 = bank;
                addr[COL_W-1:0]    = col;
                addr[AP_BIT]       = ap;
            end
            OP_PRE: begin
                ba = bank;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rts_capture.sv
module rts_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              v
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
        end else begin
            v <= en;
            if (en) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/rd_trunc_seq.sv
module rd_trunc_seq
    import rts_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_cas_lat,
    input  logic [1:0]           cfg_bl_code,
    input  logic                 cfg_full_page,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [COL_W-1:0]     req_col,
    input  logic [COL_W:0]       req_len,
    input  logic                 req_ap,
    input  logic                 req_close,
    output logic                 req_err,
    output logic                 busy,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ADDR_W-1:0]    sd_addr,
    output logic [DATA_W/8-1:0]  sd_dqm,
    input  logic [DATA_W-1:0]    sd_dq_in,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);
    localparam int LEN_W = COL_W + 1;
    localparam int CNT_W = LEN_W + 1;
    localparam int DQM_W = DATA_W / 8;

    rts_state_e        state, state_nx;
    logic [CNT_W-1:0]  cyc;
    logic [CNT_W-1:0]  cyc_inc;
    logic [CNT_W-1:0]  last_cyc;
    logic [LEN_W-1:0]  lat_len;
    logic [1:0]        lat_cl;
    logic [BANK_W-1:0] lat_bank;
    logic [COL_W-1:0]  lat_col;
    logic              lat_ap;
    logic              lat_trunc;
    logic              lat_pre;

    logic              chk_ok, chk_trunc, chk_pre;
    logic              idle_like;
    logic              accept;
    logic              last;
    logic              cap_en;
    rts_op_e           op;
    rts_pins_t         pins;

    rts_req_check #(.COL_W(COL_W)) u_check (
        .cas_lat   (cfg_cas_lat),
        .bl_code   (cfg_bl_code),
        .full_page (cfg_full_page),
        .len       (req_len),
        .ap        (req_ap),
        .close_row (req_close),
        .ok        (chk_ok),
        .trunc     (chk_trunc),
        .use_pre   (chk_pre)
    );

    assign idle_like = (state == ST_IDLE) || (state == ST_REJECT);
    assign accept    = idle_like && req_valid && chk_ok;
    assign cyc_inc   = cyc + CNT_W'(1);
    assign last_cyc  = CNT_W'(lat_cl) + CNT_W'(lat_len) - CNT_W'(1);
    assign last      = (cyc == last_cyc);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_REJECT: begin
                if (req_valid) begin
                    state_nx = chk_ok ? ST_ISSUE : ST_REJECT;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_ISSUE, ST_GAP: begin
                if (lat_trunc) begin
                    state_nx = (cyc_inc == CNT_W'(lat_len)) ? ST_STOP : ST_GAP;
                end else begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_STOP, ST_DRAIN: begin
                state_nx = last ? ST_IDLE : ST_DRAIN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // request latch and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc       <= '0;
            lat_len   <= '0;
            lat_cl    <= 2'd1;
            lat_bank  <= '0;
            lat_col   <= '0;
            lat_ap    <= 1'b0;
            lat_trunc <= 1'b0;
            lat_pre   <= 1'b0;
        end else if (accept) begin
            cyc       <= '0;
            lat_len   <= req_len;
            lat_cl    <= cfg_cas_lat;
            lat_bank  <= req_bank;
            lat_col   <= req_col;
            lat_ap    <= req_ap;
            lat_trunc <= chk_trunc;
            lat_pre   <= chk_pre;
        end else if (!idle_like) begin
            cyc <= cyc_inc;
        end
    end

    // outputs
    always_comb begin
        op      = OP_NOP;
        busy    = 1'b0;
        req_err = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_REJECT: req_err = 1'b1;
            ST_ISSUE: begin
                op   = OP_READ;
                busy = 1'b1;
            end
            ST_GAP, ST_DRAIN: busy = 1'b1;
            ST_STOP: begin
                op   = lat_pre ? OP_PRE : OP_TERM;
                busy = 1'b1;
            end
            default: ;
        endcase
        sd_dqm = busy ? '0 : {DQM_W{1'b1}};
        cap_en = busy && (cyc >= CNT_W'(lat_cl));
    end

    rts_cmd_enc #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) u_enc (
        .op   (op),
        .bank (lat_bank),
        .col  (lat_col),
        .ap   (lat_ap),
        .pins (pins),
        .ba   (sd_ba),
        .addr (sd_addr)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    rts_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_en),
        .d     (sd_dq_in),
        .q     (rd_data),
        .v     (rd_valid)
    );

endmodule

// File: rtl/rts_chk.sv
module rts_chk #(
    parameter int DQM_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [DQM_W-1:0] sd_dqm,
    input logic             busy,
    input logic             rd_valid,
    input logic             req_err
);
    logic [3:0] cmd;
    logic is_read, is_term, is_pre, is_nop;

    assign cmd     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_read = (cmd == 4'b0101);
    assign is_term = (cmd == 4'b0110);
    assign is_pre  = (cmd == 4'b0010);
    assign is_nop  = (cmd == 4'b0111);

    // R2
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_read || is_term || is_pre || is_nop);

    // R3
    read_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |-> !$past(busy));

    // R3
    busy_rise_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> is_read);

    // R5
    stop_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_term || is_pre) |-> busy);

    // R9
    busy_fall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rd_valid);

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(busy));

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!busy && is_nop));

    // R11
    dqm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sd_dqm == '0));

    // R11
    dqm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_dqm == {DQM_W{1'b1}}));

endmodule

bind rd_trunc_seq rts_chk #(.DQM_W(DATA_W/8)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dqm   (sd_dqm),
    .busy     (busy),
    .rd_valid (rd_valid),
    .req_err  (req_err)
);

// File: tb/test_rd_trunc_seq.sv
`timescale 1ns/1ps
module test_rd_trunc_seq;

    localparam logic [3:0] C_READ = 4'b0101;
    localparam logic [3:0] C_TERM = 4'b0110;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_NOP  = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_cas_lat = 2'd1;
    logic [1:0]  cfg_bl_code = 2'd0;
    logic        cfg_full_page = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_col = '0;
    logic [8:0]  req_len = '0;
    logic        req_ap = 1'b0;
    logic        req_close = 1'b0;
    logic        req_err, busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_valid;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [3:0]  sd_dqm;
    logic [31:0] sd_dq_in = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    rd_trunc_seq i_rd_trunc_seq (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_bl_code(cfg_bl_code),
        .cfg_full_page(cfg_full_page), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_len(req_len), .req_ap(req_ap), .req_close(req_close),
        .req_err(req_err), .busy(busy), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [31:0] dq_pat(int c);
        return 32'h9E37_79B9 * c + 32'h0000_1234;
    endfunction

    always @(negedge clk) sd_dq_in <= dq_pat(cyc_cnt);

    function automatic int burst_of(logic [1:0] code, logic fp);
        return fp ? 256 : (1 << code);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic run_txn(input logic [1:0] bank, input logic [7:0] col, input int len,
                           input logic ap, input logic cls, input int cl,
                           input logic [1:0] code, input logic fp, input bit junk);
        int t0, burst;
        bit trunc;
        logic [3:0] exp_cmd;
        logic [11:0] exp_addr;
        logic [1:0] exp_ba;
        bit exp_busy, exp_valid;
        string rtag;
        @(negedge clk);
        cfg_cas_lat = 2'(cl); cfg_bl_code = code; cfg_full_page = fp;
        req_valid = 1'b1; req_bank = bank; req_col = col; req_len = 9'(len);
        req_ap = ap; req_close = cls;
        @(negedge clk);
        req_valid = 1'b0;
        t0 = cyc_cnt;
        burst = burst_of(code, fp);
        trunc = (len < burst);
        for (int k = 0; k <= cl + len + 2; k++) begin
            if (k > 0) @(negedge clk);
            exp_cmd = C_NOP; exp_addr = '0; exp_ba = '0; rtag = "R7";
            if (k == 0) begin
                exp_cmd = C_READ; exp_ba = bank;
                exp_addr = {1'b0, ap, 2'b00, col};
                rtag = "R3";
            end else if (trunc && k == len) begin
                exp_cmd = cls ? C_PRE : C_TERM;
                exp_ba = cls ? bank : 2'b00;
                rtag = cls ? "R6" : "R5";
            end else if (trunc) begin
                rtag = "R2";
            end
            // R2 R3 R5 R6 R7 R10: command, bank and address per slot
            check(pins_now() == exp_cmd, rtag, "cmd", 64'(pins_now()), 64'(exp_cmd));
            check(sd_addr == exp_addr && sd_ba == exp_ba, rtag, "addr/ba",
                  64'({sd_ba, sd_addr}), 64'({exp_ba, exp_addr}));
            exp_busy = (k <= cl + len - 1);
            check(busy == exp_busy, "R9", "busy", 64'(busy), 64'(exp_busy));
            check(req_err == 1'b0, "R9", "req_err while busy/txn", 64'(req_err), 64'd0);
            exp_valid = (k >= cl + 1) && (k <= cl + len);
            check(rd_valid == exp_valid, "R4", "rd_valid", 64'(rd_valid), 64'(exp_valid));
            if (exp_valid)
                check(rd_data == dq_pat(t0 + k - 1), "R4", "rd_data",
                      64'(rd_data), 64'(dq_pat(t0 + k - 1)));
            check(sd_dqm == (exp_busy ? 4'h0 : 4'hF), "R11", "dqm",
                  64'(sd_dqm), 64'(exp_busy ? 4'h0 : 4'hF));
            if (junk && k == 0) begin
                req_valid = 1'b1; req_bank = 2'($urandom); req_col = 8'($urandom);
                req_len = 9'(1 + $urandom % 4); req_ap = 1'b0; cfg_cas_lat = 2'd1;
            end
            if (k == 1) req_valid = 1'b0;
        end
    endtask

    task automatic run_bad(input int len, input logic ap, input int cl,
                           input logic [1:0] code, input logic fp);
        @(negedge clk);
        cfg_cas_lat = 2'(cl); cfg_bl_code = code; cfg_full_page = fp;
        req_valid = 1'b1; req_len = 9'(len); req_ap = ap; req_close = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, "R8", "req_err", 64'(req_err), 64'd1);
        check(busy == 1'b0, "R8", "busy", 64'(busy), 64'd0);
        check(pins_now() == C_NOP, "R8", "cmd", 64'(pins_now()), 64'(C_NOP));
        @(negedge clk);
        check(req_err == 1'b0, "R8", "req_err second cycle", 64'(req_err), 64'd0);
        check(pins_now() == C_NOP, "R8", "cmd no READ", 64'(pins_now()), 64'(C_NOP));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && rd_valid == 0 && req_err == 0, "R1", "flags in reset",
              64'({busy, rd_valid, req_err}), 64'd0);
        check(pins_now() == C_NOP && sd_dqm == 4'hF, "R1", "bus in reset",
              64'({pins_now(), sd_dqm}), 64'({C_NOP, 4'hF}));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && pins_now() == C_NOP, "R1", "after reset",
              64'({busy, pins_now()}), 64'({1'b0, C_NOP}));

        // directed: same cut length under each latency (R5)
        run_txn(2'd1, 8'h10, 4, 1'b0, 1'b0, 1, 2'd3, 1'b0, 1'b0);
        run_txn(2'd2, 8'h20, 4, 1'b0, 1'b0, 2, 2'd3, 1'b0, 1'b0);
        run_txn(2'd3, 8'h30, 4, 1'b0, 1'b0, 3, 2'd3, 1'b0, 1'b0);
        // R6: precharge stop
        run_txn(2'd2, 8'h44, 3, 1'b0, 1'b1, 2, 2'd3, 1'b0, 1'b0);
        run_txn(2'd1, 8'h01, 1, 1'b0, 1'b1, 3, 2'd2, 1'b0, 1'b0);
        // R7 / R10: full-length bursts, single word, auto precharge
        run_txn(2'd0, 8'h05, 1, 1'b0, 1'b0, 1, 2'd0, 1'b0, 1'b0);
        run_txn(2'd3, 8'hF8, 8, 1'b1, 1'b0, 3, 2'd3, 1'b0, 1'b0);
        run_txn(2'd1, 8'h02, 2, 1'b1, 1'b1, 2, 2'd1, 1'b0, 1'b0);
        // R10: full page cut and full page complete
        run_txn(2'd2, 8'h00, 1, 1'b0, 1'b0, 1, 2'd0, 1'b1, 1'b0);
        run_txn(2'd0, 8'h80, 37, 1'b0, 1'b0, 3, 2'd1, 1'b1, 1'b1);
        run_txn(2'd1, 8'h00, 256, 1'b0, 1'b0, 2, 2'd2, 1'b1, 1'b0);
        // R8: refused requests
        run_bad(3, 1'b1, 2, 2'd3, 1'b0);
        run_bad(4, 1'b1, 1, 2'd0, 1'b1);
        run_bad(0, 1'b0, 2, 2'd2, 1'b0);
        run_bad(5, 1'b0, 3, 2'd2, 1'b0);
        run_bad(2, 1'b0, 0, 2'd3, 1'b0);

        // random mix, with stray requests while busy (R9)
        for (int n = 0; n < 60; n++) begin
            logic fp, ap, cls;
            logic [1:0] code;
            int cl, len, burst;
            fp = ($urandom % 4 == 0);
            code = 2'($urandom % 4);
            cl = 1 + $urandom % 3;
            burst = burst_of(code, fp);
            len = fp ? 1 + $urandom % 24 : 1 + $urandom % burst;
            ap = (!fp && len == burst) ? 1'($urandom % 2) : 1'b0;
            cls = 1'($urandom % 2);
            run_txn(2'($urandom), 8'($urandom), len, ap, cls, cl, code, fp, 1'($urandom % 2));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule